// File: doc/BRIEF.md
# Two-Level Majority Coincidence Trigger

This block turns four discriminated time-of-flight plane lines and a small bundle of calorimeter hit lines into a two-stage trigger decision. Each plane line is first widened into a window of a programmable number of clock cycles, so hits that arrive a few cycles apart can still overlap. When at least three enabled planes are active at the same time, the block issues a one-cycle fast trigger.

On that same edge the block captures the plane and calorimeter lines into one hit vector. It compares this vector against a table of allowed patterns that software loads over a simple write port. When a pattern matches, a one-cycle level-1 pulse leaves the block a programmable number of cycles after the fast trigger. That pulse starts digitization in every subdetector. BUSY rises with the pulse and stays high until every subdetector reports done.

While BUSY is high, new coincidences produce no trigger. The block counts them as dead time instead. A fast trigger that finds no matching pattern, or whose latency leaves too little time for the match result, lets the block return to idle quietly.

Top module: `majority_l1_trigger`

## Requirements
- R1: A hit on an enabled plane keeps that plane active for `win_len` cycles after the sampling edge. With `win_len` = 0, or with the plane's `plane_en` bit clear, the plane never counts toward the coincidence.
- R2: While idle, the first cycle in which at least three enabled planes are active at once produces a `fast_trig` pulse one cycle long, on the cycle after that edge. No second pulse follows while the planes stay active.
- R3: Two active planes, however long they overlap, produce no `fast_trig`.
- R4: The captured vector carries plane i in bit i (bits 0 to 3) and `cal_hit[j]` in bit 4+j, both sampled on the edge that fires. A table entry matches when ((vector XOR value) AND care) is zero, and only if the entry was written since reset. An empty table never matches.
- R5: On a match, `l1_trig` is a one-cycle pulse exactly `l1_lat` cycles after `fast_trig`, for any `l1_lat` of 2 or more.
- R6: When `l1_lat` is 0 or 1, the match result comes too late: no `l1_trig`, no `busy`, and the block returns to idle.
- R7: A fast trigger with no matching entry raises neither `l1_trig` nor `busy`, and a later coincidence can trigger again.
- R8: `busy` rises in the same cycle as `l1_trig`. It falls only after an edge at which every `sub_done` bit is 1, and a partial set of done bits keeps it high.
- R9: A coincidence that arrives while `busy` is high produces no `fast_trig` and increments `dead_cnt` by exactly one.
- R10: After reset, `fast_trig`, `l1_trig`, `busy` and `dead_cnt` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| plane_hit | input | 4 | Discriminated hit per time-of-flight plane |
| cal_hit | input | N_CAL | Calorimeter hit lines |
| plane_en | input | 4 | Per-plane enable mask |
| win_len | input | WIN_W | Stretch window in cycles |
| l1_lat | input | LAT_W | Level-1 latency in cycles after fast trigger |
| tbl_we | input | 1 | Pattern table write strobe |
| tbl_addr | input | AW | Pattern table entry index |
| tbl_value | input | N_PLANES+N_CAL | Match value for the entry |
| tbl_care | input | N_PLANES+N_CAL | Care mask for the entry |
| sub_done | input | N_SUB | Readout-complete flag per subdetector |
| fast_trig | output | 1 | Fast coincidence trigger pulse |
| l1_trig | output | 1 | Level-1 trigger pulse |
| busy | output | 1 | Event collection in progress |
| dead_cnt | output | DW | Coincidences lost while busy |

## Verification
The bench staggers plane hits across cycles so that coincidence depends on the window. With a window of one cycle, a design that stretched too long would trigger, and one that did not stretch at all would miss the three-cycle staggered case. Latencies of 1 and 2 bracket the point where the match result is just ready, so a design that used a stale match value would issue a level-1 at latency 1. A partial set of done bits and a coincidence while busy catch a design that releases BUSY early or lets a trigger through. An empty table and a mismatching vector confirm that the design drops back to idle without a level-1.

// File: rtl/trig_pkg.sv
package trig_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_BUSY = 2'd2
  } seq_state_e;

  // number of set bits in a vector (up to 32 bits)
  function automatic int unsigned popcount(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

  // masked equality used by every pattern entry
  function automatic logic entry_hit(input logic [31:0] vec,
                                     input logic [31:0] value,
                                     input logic [31:0] care);
    return ((vec ^ value) & care) == 32'd0;
  endfunction

endpackage

// File: rtl/plane_stretch.sv
module plane_stretch #(
  parameter int WIN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             en,
  input  logic [WIN_W-1:0] win_len,
  output logic             active
);
  logic [WIN_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (hit && en)        cnt_q <= win_len;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0) && en;

  // R1
  stretch_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && en && win_len != '0 && $stable(en)) |=> active);
endmodule

// File: rtl/pattern_table.sv
module pattern_table
  import trig_pkg::*;
#(
  parameter int N_PAT = 16,
  parameter int VW    = 8,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [VW-1:0] value,
  input  logic [VW-1:0] care,
  input  logic [VW-1:0] vec,
  output logic          match_q
);
  logic [VW-1:0]    val_q  [N_PAT];
  logic [VW-1:0]    care_q [N_PAT];
  logic [N_PAT-1:0] vld_q;
  logic [N_PAT-1:0] ent_hit;

  for (genvar g = 0; g < N_PAT; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        val_q[g]  <= '0;
        care_q[g] <= '0;
        vld_q[g]  <= 1'b0;
      end else if (we && addr == AW'(g)) begin
        val_q[g]  <= value;
        care_q[g] <= care;
        vld_q[g]  <= 1'b1;
      end
    end
    assign ent_hit[g] = vld_q[g] &&
                        entry_hit(32'(vec), 32'(val_q[g]), 32'(care_q[g]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= |ent_hit;
  end

  // R4
  table_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q == '0) |=> !match_q);
endmodule

// File: rtl/trig_sequencer.sv
module trig_sequencer
  import trig_pkg::*;
#(
  parameter int N_SUB = 3,
  parameter int LAT_W = 8,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             coin,
  input  logic             match_q,
  input  logic [LAT_W-1:0] l1_lat,
  input  logic [N_SUB-1:0] sub_done,
  output logic             cap_en,
  output logic             fast_trig,
  output logic             l1_trig,
  output logic             busy,
  output logic [DW-1:0]    dead_cnt
);
  seq_state_e       state_q;
  logic             coin_q;
  logic [LAT_W-1:0] lat_cnt;
  logic             fire;
  logic             decide;
  logic             match_ready;

  assign fire        = coin && !coin_q;
  assign cap_en      = (state_q == ST_IDLE) && fire;
  assign decide      = (state_q == ST_WAIT) && (lat_cnt >= l1_lat);
  assign match_ready = lat_cnt >= LAT_W'(2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      coin_q    <= 1'b0;
      lat_cnt   <= '0;
      fast_trig <= 1'b0;
      l1_trig   <= 1'b0;
      busy      <= 1'b0;
      dead_cnt  <= '0;
    end else begin
      coin_q    <= coin;
      fast_trig <= 1'b0;
      l1_trig   <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (fire) begin
          fast_trig <= 1'b1;
          lat_cnt   <= LAT_W'(1);
          state_q   <= ST_WAIT;
        end
        ST_WAIT: if (decide) begin
          if (match_ready && match_q) begin
            l1_trig <= 1'b1;
            busy    <= 1'b1;
            state_q <= ST_BUSY;
          end else begin
            state_q <= ST_IDLE;
          end
        end else begin
          lat_cnt <= lat_cnt + 1'b1;
        end
        ST_BUSY: begin
          if (fire) dead_cnt <= dead_cnt + 1'b1;
          if (&sub_done) begin
            busy    <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  fast_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fast_trig |=> !fast_trig);
  // R8
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> l1_trig);
  // R8
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(&sub_done));
  // R9
  dead_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dead_cnt != $past(dead_cnt)) |-> $past(busy));
  // R9
  no_fast_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fast_trig |-> !busy);
  // R5
  l1_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l1_trig |-> !$past(busy));
endmodule

// File: rtl/majority_l1_trigger.sv
module majority_l1_trigger
  import trig_pkg::*;
#(
  parameter int N_PLANES = 4,
  parameter int MAJ_MIN  = 3,
  parameter int N_CAL    = 4,
  parameter int N_PAT    = 16,
  parameter int N_SUB    = 3,
  parameter int WIN_W    = 4,
  parameter int LAT_W    = 8,
  parameter int DW       = 8,
  parameter int AW       = (N_PAT > 1) ? $clog2(N_PAT) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_PLANES-1:0]       plane_hit,
  input  logic [N_CAL-1:0]          cal_hit,
  input  logic [N_PLANES-1:0]       plane_en,
  input  logic [WIN_W-1:0]          win_len,
  input  logic [LAT_W-1:0]          l1_lat,
  input  logic                      tbl_we,
  input  logic [AW-1:0]             tbl_addr,
  input  logic [N_PLANES+N_CAL-1:0] tbl_value,
  input  logic [N_PLANES+N_CAL-1:0] tbl_care,
  input  logic [N_SUB-1:0]          sub_done,
  output logic                      fast_trig,
  output logic                      l1_trig,
  output logic                      busy,
  output logic [DW-1:0]             dead_cnt
);
  localparam int VW = N_PLANES + N_CAL;

  logic [N_PLANES-1:0] active;
  logic                coin;
  logic                cap_en;
  logic                match_q;
  logic [VW-1:0]       cap_q;

  for (genvar p = 0; p < N_PLANES; p++) begin : g_plane
    plane_stretch #(.WIN_W(WIN_W)) i_stretch (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit    (plane_hit[p]),
      .en     (plane_en[p]),
      .win_len(win_len),
      .active (active[p])
    );
  end

  assign coin = popcount(32'(active)) >= MAJ_MIN;

  always_ff @(posedge clk) begin
    if (!rst_n)      cap_q <= '0;
    else if (cap_en) cap_q <= {cal_hit, active};
  end

  pattern_table #(.N_PAT(N_PAT), .VW(VW), .AW(AW)) i_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (tbl_we),
    .addr   (tbl_addr),
    .value  (tbl_value),
    .care   (tbl_care),
    .vec    (cap_q),
    .match_q(match_q)
  );

  trig_sequencer #(.N_SUB(N_SUB), .LAT_W(LAT_W), .DW(DW)) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .coin     (coin),
    .match_q  (match_q),
    .l1_lat   (l1_lat),
    .sub_done (sub_done),
    .cap_en   (cap_en),
    .fast_trig(fast_trig),
    .l1_trig  (l1_trig),
    .busy     (busy),
    .dead_cnt (dead_cnt)
  );

  // R2
  fast_needs_majority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fast_trig |-> $past(popcount(32'(active)) >= MAJ_MIN));
  // R3
  two_planes_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (popcount(32'(active)) < MAJ_MIN) |=> !fast_trig);
endmodule

// File: tb/test_majority_l1_trigger.sv
module test_majority_l1_trigger;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] plane_hit, cal_hit, plane_en, win_len, tbl_addr;
  logic [7:0] l1_lat, tbl_value, tbl_care, dead_cnt;
  logic       tbl_we;
  logic [2:0] sub_done;
  logic       fast_trig, l1_trig, busy;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  majority_l1_trigger i_majority_l1_trigger (
    .clk(clk), .rst_n(rst_n), .plane_hit(plane_hit), .cal_hit(cal_hit),
    .plane_en(plane_en), .win_len(win_len), .l1_lat(l1_lat),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_value(tbl_value),
    .tbl_care(tbl_care), .sub_done(sub_done), .fast_trig(fast_trig),
    .l1_trig(l1_trig), .busy(busy), .dead_cnt(dead_cnt)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_entry(input logic [3:0] a, input logic [7:0] v,
                             input logic [7:0] c);
    tbl_we = 1'b1; tbl_addr = a; tbl_value = v; tbl_care = c;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // drive planes for one cycle, hold cal, record first fast/l1/busy cycle
  task automatic shoot(input logic [3:0] planes, input logic [3:0] cal,
                       input int span, output int f_at, output int l_at,
                       output int b_at);
    f_at = -1; l_at = -1; b_at = -1;
    plane_hit = planes; cal_hit = cal;
    for (int i = 1; i <= span; i++) begin
      @(negedge clk);
      if (fast_trig && f_at < 0) f_at = i;
      if (l1_trig && l_at < 0)   l_at = i;
      if (busy && b_at < 0)      b_at = i;
      plane_hit = '0;
    end
    cal_hit = '0;
  endtask

  task automatic release_busy(input string req);
    sub_done = 3'b111;
    @(negedge clk);
    check({req, " busy released"}, busy, 0);
    sub_done = '0;
    idle(2);
  endtask

  task automatic t_reset;
    check("R10 fast", fast_trig, 0);
    check("R10 l1", l1_trig, 0);
    check("R10 busy", busy, 0);
    check("R10 dead", dead_cnt, 0);
  endtask

  task automatic t_empty_table;
    int f, l, b;
    shoot(4'b0111, 4'b0000, 10, f, l, b);
    check("R4 empty fast", f, 2);
    check("R4 empty no l1", l, -1);
  endtask

  task automatic t_match_busy_dead;
    int f, l, b;
    shoot(4'b0111, 4'b0000, 10, f, l, b);
    check("R2 fast cycle", f, 2);
    check("R5 l1 latency", l, 6);
    check("R8 busy with l1", b, 6);
    sub_done = 3'b011;
    idle(3);
    check("R8 partial done", busy, 1);
    shoot(4'b1111, 4'b0000, 6, f, l, b);
    check("R9 no fast while busy", f, -1);
    check("R9 dead count", dead_cnt, 1);
    release_busy("R8");
  endtask

  task automatic t_no_match;
    int f, l, b;
    shoot(4'b1011, 4'b0000, 10, f, l, b);
    check("R7 fast", f, 2);
    check("R7 no l1", l, -1);
    check("R7 no busy", b, -1);
    shoot(4'b1011, 4'b0001, 10, f, l, b);
    check("R4 cal bit match fast", f, 2);
    check("R4 cal bit match l1", l, 6);
    release_busy("R7");
  endtask

  task automatic t_two_planes;
    int f, l, b;
    shoot(4'b0011, 4'b0000, 8, f, l, b);
    check("R3 two planes", f, -1);
    plane_en = 4'b1011;
    shoot(4'b0111, 4'b0000, 8, f, l, b);
    check("R1 disabled plane", f, -1);
    plane_en = 4'b1111;
    win_len = 4'd0;
    shoot(4'b1111, 4'b0000, 8, f, l, b);
    check("R1 zero window", f, -1);
    win_len = 4'd3;
  endtask

  task automatic stagger(input int span, output int f_at, output int l_at);
    f_at = -1; l_at = -1;
    plane_hit = 4'b0001;
    for (int i = 1; i <= span; i++) begin
      @(negedge clk);
      if (fast_trig && f_at < 0) f_at = i;
      if (l1_trig && l_at < 0)   l_at = i;
      plane_hit = (i == 1) ? 4'b0010 : (i == 2) ? 4'b0100 : 4'b0000;
    end
  endtask

  task automatic t_stagger;
    int f, l;
    stagger(12, f, l);
    check("R1 staggered fast", f, 4);
    check("R5 staggered l1", l, 8);
    release_busy("R1");
    win_len = 4'd1;
    stagger(10, f, l);
    check("R1 short window", f, -1);
    win_len = 4'd3;
  endtask

  task automatic t_latency;
    int f, l, b;
    l1_lat = 8'd1;
    shoot(4'b0111, 4'b0000, 10, f, l, b);
    check("R6 lat1 fast", f, 2);
    check("R6 lat1 no l1", l, -1);
    check("R6 lat1 no busy", b, -1);
    l1_lat = 8'd2;
    shoot(4'b0111, 4'b0000, 10, f, l, b);
    check("R5 lat2 l1", l, 4);
    release_busy("R5");
    l1_lat = 8'd4;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; plane_hit = '0; cal_hit = '0; plane_en = 4'hF;
    win_len = 4'd3; l1_lat = 8'd4; tbl_we = 1'b0; tbl_addr = '0;
    tbl_value = '0; tbl_care = '0; sub_done = '0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_empty_table();
    idle(3);
    write_entry(4'd0, 8'b0000_0111, 8'b0000_1111);
    write_entry(4'd1, 8'b0001_0000, 8'b0001_0000);
    t_match_busy_dead();
    t_no_match();
    t_two_planes();
    t_stagger();
    t_latency();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule